// File: doc/BRIEF.md
# Infrared Receiver FIFO and Interrupt Register Bank

This block sits between a processor bus and the run-length sampler of an infrared receiver. The sampler delivers one byte per measured pulse or gap. It also raises a pulse when a packet ends. The bank stores the bytes in a 16-entry first-in first-out buffer, which software drains by reading the data register. The bank also holds the configuration that the sampler consumes: enables, operating mode, input inversion, noise threshold and idle threshold. It raises one level-sensitive interrupt line.

The bus is a plain synchronous port. A write takes effect at the clock edge where the write strobe is high. Read data is valid in the same cycle as the read strobe, and a read of the data register pops the oldest byte at that edge. The status register combines three event flags, which software clears by writing ones, with a live count of the bytes waiting in the buffer. The data-available event fires when the occupancy climbs to a level that software programs.

Top module: `irrx_regs`

## Requirements
- R1: After reset every register reads 0x0000_0000, the buffer is empty, `irq` is low and all configuration outputs are zero.
- R2: Offsets 0x00 (bit 0 global enable, bit 1 receive enable, bits 5:4 mode), 0x10 (bit 2 invert), 0x34 (bits 7:2 noise threshold, bits 15:8 idle threshold) and 0x2C (bit 0 overflow enable, bit 1 packet-end enable, bit 4 data-available enable, bits 11:8 trigger level minus one) read back only these fields, with all other bits zero, and drive the matching `cfg_*` outputs.
- R3: While global enable and receive enable are both 1, each `smp_valid` byte is appended to the buffer. A read of offset 0x20 returns the oldest byte in bits 7:0 and removes it.
- R4: Status bits 13:8 at offset 0x30 show the current occupancy (0 to 16). A push and a pop in the same cycle leave the occupancy unchanged.
- R5: A byte that arrives while the occupancy is 16 is dropped, even if a pop falls in the same cycle. It sets the overflow flag (status bit 0), and the occupancy stays 16.
- R6: A read of offset 0x20 while the buffer is empty returns zero and leaves the occupancy at zero.
- R7: An `smp_pkt_end` pulse while reception is active sets the packet-end flag (status bit 1).
- R8: The data-available flag (status bit 4) is set when the occupancy rises from below to at or above the trigger level, which is the 0x2C bits 11:8 field plus one.
- R9: Writing offset 0x30 clears each flag whose bit in the low byte is 1 (bits 0, 1, 4) and leaves the others. A flag set in the same cycle as its clear stays set.
- R10: `irq` is high exactly when some status flag is set and its enable bit at 0x2C is 1.
- R11: While receive enable is 0 the buffer is emptied and held empty. Bytes and packet-end pulses that arrive while either enable is 0 are ignored and set no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe; a read of 0x20 pops |
| bus_rdata | output | 32 | Read data, valid while bus_re is high |
| smp_valid | input | 1 | Sampler byte valid |
| smp_byte | input | 8 | Sampler byte |
| smp_pkt_end | input | 1 | Sampler packet-end pulse |
| irq | output | 1 | Level interrupt |
| cfg_global_en | output | 1 | Global enable to sampler |
| cfg_rx_en | output | 1 | Receive enable to sampler |
| cfg_mode | output | 2 | Operating mode select |
| cfg_invert | output | 1 | Input polarity inversion |
| cfg_noise_thr | output | 6 | Noise threshold in samples |
| cfg_idle_thr | output | 8 | Idle threshold in samples |

## Verification
Two pairs of events can land in the same cycle. A sampler push can coincide with a bus pop of the data register, and a packet-end event can coincide with a write-one-to-clear of its own flag. The bench drives both at one clock edge. For the push and pop, it checks that the popped byte is the older one and that the reported occupancy has not moved. For the packet-end case, it checks that the flag reads back set. The full-buffer drop is also driven, and the byte order read back afterwards shows that the seventeenth byte never entered the buffer.

// File: rtl/irrx_pkg.sv
`timescale 1ns/1ps
package irrx_pkg;
  localparam logic [7:0] OFS_CTRL  = 8'h00;
  localparam logic [7:0] OFS_RXCFG = 8'h10;
  localparam logic [7:0] OFS_DATA  = 8'h20;
  localparam logic [7:0] OFS_IEN   = 8'h2C;
  localparam logic [7:0] OFS_STAT  = 8'h30;
  localparam logic [7:0] OFS_SMP   = 8'h34;

  localparam int NFLAG  = 3;
  localparam int FL_OVF = 0;
  localparam int FL_PKT = 1;
  localparam int FL_AVL = 2;

  // place the internal flags and occupancy in the status word
  function automatic logic [31:0] pack_status(logic [NFLAG-1:0] f, logic [5:0] cnt);
    return {18'b0, cnt, 3'b0, f[FL_AVL], 2'b0, f[FL_PKT], f[FL_OVF]};
  endfunction

  // written low byte of the status register -> internal clear mask
  function automatic logic [NFLAG-1:0] w1c_mask(logic [7:0] wb);
    return {wb[4], wb[1], wb[0]};
  endfunction

  // enable register field bits 0,1,4 -> internal enable vector
  function automatic logic [NFLAG-1:0] ien_bits(logic [31:0] w);
    return {w[4], w[1], w[0]};
  endfunction

  // programmed field holds level minus one
  function automatic int trig_level(logic [3:0] fld);
    return int'(fld) + 1;
  endfunction
endpackage

// File: rtl/irrx_fifo.sv
`timescale 1ns/1ps
module irrx_fifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8,
  localparam int CNT_W = $clog2(DEPTH + 1),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     dout,
  output logic [CNT_W-1:0] cnt,
  output logic [CNT_W-1:0] cnt_nxt,
  output logic             push_ok,
  output logic             push_drop,
  output logic             pop_ok
);
  logic [W-1:0]     mem [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             full, empty;

  function automatic logic [PTR_W-1:0] ptr_inc(logic [PTR_W-1:0] p);
    return (int'(p) == DEPTH - 1) ? '0 : p + 1'b1;
  endfunction

  assign full      = (cnt == CNT_W'(DEPTH));
  assign empty     = (cnt == '0);
  assign push_ok   = push && !full && !flush;
  assign push_drop = push && full && !flush;
  assign pop_ok    = pop && !empty && !flush;
  assign dout      = empty ? '0 : mem[rp];
  assign cnt_nxt   = flush ? '0 : cnt + CNT_W'(push_ok) - CNT_W'(pop_ok);

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push_ok) wp <= ptr_inc(wp);
      if (pop_ok)  rp <= ptr_inc(rp);
      cnt <= cnt_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wp] <= din;
  end
endmodule

// File: rtl/irrx_flags.sv
`timescale 1ns/1ps
module irrx_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n)      flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irrx_regs.sv
`timescale 1ns/1ps
module irrx_regs
  import irrx_pkg::*;
#(
  parameter int FIFO_DEPTH = 16,
  parameter int BYTE_W     = 8,
  parameter int ADDR_W     = 8,
  parameter int BUS_W      = 32,
  localparam int CNT_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BUS_W-1:0]  bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [BUS_W-1:0]  bus_rdata,
  input  logic              smp_valid,
  input  logic [BYTE_W-1:0] smp_byte,
  input  logic              smp_pkt_end,
  output logic              irq,
  output logic              cfg_global_en,
  output logic              cfg_rx_en,
  output logic [1:0]        cfg_mode,
  output logic              cfg_invert,
  output logic [5:0]        cfg_noise_thr,
  output logic [7:0]        cfg_idle_thr
);
  logic [NFLAG-1:0]  ien, flags, flag_set, flag_clr;
  logic [3:0]        ien_lvl;
  logic [BYTE_W-1:0] fifo_dout;
  logic [CNT_W-1:0]  fifo_cnt, cnt_nxt;
  logic              push_ok, push_drop, pop_ok;

  // named events for the checker
  logic rx_active, fifo_push, data_rd, da_cross;
  logic wr_ctrl, wr_rxcfg, wr_ien, wr_stat, wr_smp;

  assign rx_active = cfg_global_en && cfg_rx_en;
  assign fifo_push = smp_valid && rx_active;
  assign data_rd   = bus_re && (bus_addr == ADDR_W'(OFS_DATA));
  assign wr_ctrl   = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign wr_rxcfg  = bus_we && (bus_addr == ADDR_W'(OFS_RXCFG));
  assign wr_ien    = bus_we && (bus_addr == ADDR_W'(OFS_IEN));
  assign wr_stat   = bus_we && (bus_addr == ADDR_W'(OFS_STAT));
  assign wr_smp    = bus_we && (bus_addr == ADDR_W'(OFS_SMP));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_global_en <= 1'b0;
      cfg_rx_en     <= 1'b0;
      cfg_mode      <= '0;
      cfg_invert    <= 1'b0;
      cfg_noise_thr <= '0;
      cfg_idle_thr  <= '0;
      ien           <= '0;
      ien_lvl       <= '0;
    end else begin
      if (wr_ctrl) begin
        cfg_global_en <= bus_wdata[0];
        cfg_rx_en     <= bus_wdata[1];
        cfg_mode      <= bus_wdata[5:4];
      end
      if (wr_rxcfg) cfg_invert <= bus_wdata[2];
      if (wr_smp) begin
        cfg_noise_thr <= bus_wdata[7:2];
        cfg_idle_thr  <= bus_wdata[15:8];
      end
      if (wr_ien) begin
        ien     <= ien_bits(32'(bus_wdata));
        ien_lvl <= bus_wdata[11:8];
      end
    end
  end

  irrx_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_n),
    .flush     (!cfg_rx_en),
    .push      (fifo_push),
    .pop       (data_rd),
    .din       (smp_byte),
    .dout      (fifo_dout),
    .cnt       (fifo_cnt),
    .cnt_nxt   (cnt_nxt),
    .push_ok   (push_ok),
    .push_drop (push_drop),
    .pop_ok    (pop_ok)
  );

  assign da_cross = (int'(cnt_nxt) >= trig_level(ien_lvl)) &&
                    (int'(fifo_cnt) < trig_level(ien_lvl));

  always_comb begin
    flag_set         = '0;
    flag_set[FL_OVF] = push_drop;
    flag_set[FL_PKT] = smp_pkt_end && rx_active;
    flag_set[FL_AVL] = da_cross;
    flag_clr         = wr_stat ? w1c_mask(bus_wdata[7:0]) : '0;
  end

  irrx_flags #(.N(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (flag_set),
    .clr   (flag_clr),
    .flags (flags)
  );

  assign irq = |(flags & ien);

  always_comb begin
    logic [31:0] w;
    w = '0;
    if (bus_re) begin
      case (bus_addr)
        ADDR_W'(OFS_CTRL):  w = {26'b0, cfg_mode, 2'b0, cfg_rx_en, cfg_global_en};
        ADDR_W'(OFS_RXCFG): w = {29'b0, cfg_invert, 2'b0};
        ADDR_W'(OFS_DATA):  w = 32'(fifo_dout);
        ADDR_W'(OFS_IEN):   w = {20'b0, ien_lvl, 3'b0, ien[FL_AVL], 2'b0, ien[FL_PKT], ien[FL_OVF]};
        ADDR_W'(OFS_STAT):  w = pack_status(flags, 6'(fifo_cnt));
        ADDR_W'(OFS_SMP):   w = {16'b0, cfg_idle_thr, cfg_noise_thr, 2'b0};
        default:            w = '0;
      endcase
    end
    bus_rdata = BUS_W'(w);
  end
endmodule

// File: rtl/irrx_regs_chk.sv
`timescale 1ns/1ps
module irrx_regs_chk #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5,
  parameter int BUS_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_active,
  input logic             rx_en,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic             push_drop,
  input logic             pop_ok,
  input logic             data_rd,
  input logic [BUS_W-1:0] bus_rdata,
  input logic             smp_pkt_end,
  input logic             da_cross,
  input logic [2:0]       flags,
  input logic [2:0]       ien,
  input logic             irq
);
  AST_COUNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(fifo_cnt) <= DEPTH); // R4
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    rx_en |=> (int'(fifo_cnt) <= int'($past(fifo_cnt)) + 1) &&
              (int'(fifo_cnt) + 1 >= int'($past(fifo_cnt)))); // R4
  AST_DROP_SETS_OVF: assert property (@(posedge clk) disable iff (!rst_n)
    push_drop |=> flags[0]); // R5
  AST_DROP_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (push_drop && !pop_ok && rx_en) |=> fifo_cnt == $past(fifo_cnt)); // R5
  AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd && fifo_cnt == '0) |-> bus_rdata == '0); // R6
  AST_PKT_END_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_pkt_end && rx_active) |=> flags[1]); // R7
  AST_AVAIL_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    da_cross |=> flags[2]); // R8
  AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (ien == '0 || flags == '0) |-> !irq); // R10
  AST_FLUSH_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> fifo_cnt == '0); // R11
endmodule

bind irrx_regs irrx_regs_chk #(.DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .BUS_W(BUS_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rx_active   (rx_active),
  .rx_en       (cfg_rx_en),
  .fifo_cnt    (fifo_cnt),
  .push_drop   (push_drop),
  .pop_ok      (pop_ok),
  .data_rd     (data_rd),
  .bus_rdata   (bus_rdata),
  .smp_pkt_end (smp_pkt_end),
  .da_cross    (da_cross),
  .flags       (flags),
  .ien         (ien),
  .irq         (irq)
);

// File: tb/tb_irrx_regs.sv
`timescale 1ns/1ps
module tb_irrx_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic        bus_we = 1'b0, bus_re = 1'b0;
  logic [31:0] bus_rdata;
  logic        smp_valid = 1'b0, smp_pkt_end = 1'b0;
  logic [7:0]  smp_byte = '0;
  logic        irq, cfg_global_en, cfg_rx_en, cfg_invert;
  logic [1:0]  cfg_mode;
  logic [5:0]  cfg_noise_thr;
  logic [7:0]  cfg_idle_thr;

  int n_chk = 0, n_bad = 0;

  always #2.5 clk = ~clk;

  irrx_regs dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_re(bus_re), .bus_rdata(bus_rdata),
    .smp_valid(smp_valid), .smp_byte(smp_byte), .smp_pkt_end(smp_pkt_end),
    .irq(irq), .cfg_global_en(cfg_global_en), .cfg_rx_en(cfg_rx_en),
    .cfg_mode(cfg_mode), .cfg_invert(cfg_invert),
    .cfg_noise_thr(cfg_noise_thr), .cfg_idle_thr(cfg_idle_thr)
  );

  // {req, op, addr, data, expected}; op 0 write, 1 read+compare, 2 push, 3 packet end
  localparam int NV = 32;
  localparam logic [77:0] VEC [NV] = '{
    {4'd1, 2'd1, 8'h00, 32'h0, 32'h0},               // R1
    {4'd1, 2'd1, 8'h30, 32'h0, 32'h0},               // R1
    {4'd1, 2'd1, 8'h2C, 32'h0, 32'h0},               // R1
    {4'd2, 2'd0, 8'h00, 32'h33, 32'h0},              // R2
    {4'd2, 2'd1, 8'h00, 32'h0, 32'h33},              // R2
    {4'd2, 2'd0, 8'h10, 32'hFFFF_FFFF, 32'h0},       // R2
    {4'd2, 2'd1, 8'h10, 32'h0, 32'h4},               // R2
    {4'd2, 2'd0, 8'h34, 32'hFFFF_FFFF, 32'h0},       // R2
    {4'd2, 2'd1, 8'h34, 32'h0, 32'hFFFC},            // R2
    {4'd2, 2'd0, 8'h2C, 32'h313, 32'h0},             // R2
    {4'd2, 2'd1, 8'h2C, 32'h0, 32'h313},             // R2
    {4'd3, 2'd2, 8'h00, 32'hA1, 32'h0},              // R3
    {4'd3, 2'd2, 8'h00, 32'hA2, 32'h0},              // R3
    {4'd3, 2'd2, 8'h00, 32'hA3, 32'h0},              // R3
    {4'd8, 2'd1, 8'h30, 32'h0, 32'h0300},            // R8 below level
    {4'd3, 2'd2, 8'h00, 32'hA4, 32'h0},              // R3
    {4'd8, 2'd1, 8'h30, 32'h0, 32'h0410},            // R8 reached level
    {4'd3, 2'd1, 8'h20, 32'h0, 32'hA1},              // R3
    {4'd3, 2'd1, 8'h20, 32'h0, 32'hA2},              // R3
    {4'd4, 2'd1, 8'h30, 32'h0, 32'h0210},            // R4
    {4'd9, 2'd0, 8'h30, 32'h10, 32'h0},              // R9
    {4'd9, 2'd1, 8'h30, 32'h0, 32'h0200},            // R9
    {4'd3, 2'd1, 8'h20, 32'h0, 32'hA3},              // R3
    {4'd3, 2'd1, 8'h20, 32'h0, 32'hA4},              // R3
    {4'd6, 2'd1, 8'h20, 32'h0, 32'h0},               // R6
    {4'd6, 2'd1, 8'h30, 32'h0, 32'h0},               // R6
    {4'd7, 2'd3, 8'h00, 32'h0, 32'h0},               // R7
    {4'd7, 2'd1, 8'h30, 32'h0, 32'h2},               // R7
    {4'd9, 2'd0, 8'h30, 32'h0, 32'h0},               // R9
    {4'd9, 2'd1, 8'h30, 32'h0, 32'h2},               // R9
    {4'd9, 2'd0, 8'h30, 32'hFF, 32'h0},              // R9
    {4'd9, 2'd1, 8'h30, 32'h0, 32'h0}                // R9
  };

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_re = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_re = 1'b0;
  endtask

  task automatic push(logic [7:0] b);
    @(negedge clk); smp_byte = b; smp_valid = 1'b1;
    @(negedge clk); smp_valid = 1'b0;
  endtask

  task automatic pend();
    @(negedge clk); smp_pkt_end = 1'b1;
    @(negedge clk); smp_pkt_end = 1'b0;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: port state after reset
    check("R1", {24'b0, irq, cfg_global_en, cfg_rx_en, cfg_mode, cfg_invert, 2'b0}, 32'h0);
    check("R1", {16'b0, cfg_idle_thr, cfg_noise_thr, 2'b0}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [77:0] v;
      v = VEC[i];
      case (v[73:72])
        2'd0: wr(v[71:64], v[63:32]);
        2'd1: begin
          rd(v[71:64], r);
          n_chk++;
          if (r !== v[31:0]) begin
            n_bad++;
            $display("FAIL R%0d vec %0d actual=%h expected=%h", v[77:74], i, r, v[31:0]);
          end
        end
        2'd2: push(v[39:32]);
        default: pend();
      endcase
    end

    // R2: configuration outputs follow the registers
    check("R2", {26'b0, cfg_mode, cfg_invert, cfg_rx_en, cfg_global_en}, 32'h1F);
    check("R2", {16'b0, cfg_idle_thr, cfg_noise_thr, 2'b0}, 32'hFFFC);

    // R5: seventeen arrivals, last one dropped
    for (int i = 0; i < 17; i++) push(8'(8'h40 + i));
    rd(8'h30, r); check("R5 full+ovf+avail", r, 32'h1011);
    check("R10 irq with enabled flags", {31'b0, irq}, 32'h1);
    for (int i = 0; i < 16; i++) begin
      rd(8'h20, r); check("R3 order after drop", r, 32'(8'h40 + i));
    end
    rd(8'h30, r); check("R5 drained", r, 32'h0011);

    // R10: masking
    wr(8'h2C, 32'h302);
    check("R10 masked", {31'b0, irq}, 32'h0);
    wr(8'h30, 32'hFF);
    pend();
    check("R10 packet-end enabled", {31'b0, irq}, 32'h1);
    wr(8'h30, 32'hFF);
    check("R9 clear drops irq", {31'b0, irq}, 32'h0);
    wr(8'h2C, 32'h313);

    // R4: push and pop in one cycle
    push(8'h51); push(8'h52);
    @(negedge clk);
    smp_byte = 8'h53; smp_valid = 1'b1; bus_addr = 8'h20; bus_re = 1'b1;
    #1 check("R4 pop returns older", bus_rdata, 32'h51);
    @(negedge clk); smp_valid = 1'b0; bus_re = 1'b0;
    rd(8'h30, r); check("R4 count unchanged", r, 32'h0200);
    rd(8'h20, r); check("R3", r, 32'h52);
    rd(8'h20, r); check("R3", r, 32'h53);

    // R9: set and clear in the same cycle
    @(negedge clk);
    smp_pkt_end = 1'b1; bus_addr = 8'h30; bus_wdata = 32'h2; bus_we = 1'b1;
    @(negedge clk); smp_pkt_end = 1'b0; bus_we = 1'b0;
    rd(8'h30, r); check("R9 set wins", r, 32'h2);
    wr(8'h30, 32'hFF);

    // R11: flush and ignore while disabled
    push(8'h61); push(8'h62); push(8'h63);
    wr(8'h00, 32'h31);
    rd(8'h30, r); check("R11 flushed", r, 32'h0);
    push(8'h99); pend();
    rd(8'h30, r); check("R11 ignored while rx off", r, 32'h0);
    wr(8'h00, 32'h33);
    rd(8'h20, r); check("R11 empty after reenable", r, 32'h0);
    wr(8'h00, 32'h32);
    push(8'h77); pend();
    wr(8'h00, 32'h33);
    rd(8'h30, r); check("R11 ignored while global off", r, 32'h0);

    finish_run();
  end
endmodule